// File: doc/BRIEF.md
# I2C Transmit Byte Streamer

This block sits between a register front end and the bit engine of an I2C master. Bytes pushed through the data port while the buffer is enabled are stored in a first-in first-out buffer. They are then handed to the bit engine one bit at a time, most significant bit first, with no software help between bytes. After each byte the block asks the bit engine for the acknowledge slot. It moves on to the next stored byte when the slave acknowledges.

A not-acknowledge from the slave stops the stream and raises a sticky flag. The stream stays halted until software flushes the buffer, and a flush also discards every unsent byte and aborts any byte in flight. A status byte reports whether the buffer holds data, a drain flag that rises once every byte has gone out, the not-acknowledge flag and an overflow flag. Start and stop conditions belong to the bit engine and are not produced here.

Top module: `i2c_tx_stream`

## Requirements
- R1: After reset `status_o` reads 0x10 (only the empty bit set), and `tx_bit_req_o` and `ack_req_o` are low.
- R2: Writes on the data port while the enable bit (bit 6 of the last control write) is 0 are ignored: nothing is stored and nothing is transmitted.
- R3: A stored byte is offered to the bit engine automatically once the buffer is enabled. `tx_bit_req_o` and `ack_req_o` are never high together.
- R4: Bytes leave in the order they were pushed. Each byte presents 8 bits MSB first on `tx_bit_o`, one per `tx_bit_done_i` pulse, and is followed by one acknowledge slot on `ack_req_o`.
- R5: Status bit 1 (drain) is set when an acknowledged byte completes while the buffer holds no further byte.
- R6: Status bit 4 (empty) reads 1 exactly when the buffer stores no byte. A byte already moved into the shifter does not count as stored.
- R7: An acknowledge slot answered with `ack_nak_i`=1 sets status bit 0 and halts the stream. No bit or acknowledge request follows until a flush.
- R8: A control write with bit 7 set discards all stored bytes, aborts a byte in flight and clears the halt. The enable bit takes bit 6 of the same write.
- R9: A push while the buffer already holds DEPTH bytes is dropped and sets the sticky status bit 5 (overflow).
- R10: Status bits 0, 1 and 5 stay set until a 1 is written to the same bit position of `stat_clr_i`. If a set and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 8 | Control value: bit 6 enable, bit 7 flush |
| data_we_i | input | 1 | Data push strobe |
| data_i | input | WIDTH | Byte to push |
| stat_clr_i | input | 8 | Write-1-to-clear pulses for status flags |
| status_o | output | 8 | Bit 0 nak, bit 1 drain, bit 4 empty, bit 5 overflow |
| tx_bit_o | output | 1 | Current bit toward the bit engine |
| tx_bit_req_o | output | 1 | A data bit is being offered |
| tx_bit_done_i | input | 1 | Bit engine has sent the offered bit |
| ack_req_o | output | 1 | Acknowledge slot requested |
| ack_done_i | input | 1 | Acknowledge slot finished |
| ack_nak_i | input | 1 | Slave did not acknowledge (valid with ack_done_i) |

## Verification
The bench builds the block with DEPTH set to 4 and WIDTH at 8, so filling the buffer and overrunning it takes only a handful of pushes. A halt caused by a not-acknowledge keeps the stored bytes in place, which lets the bench observe the full condition and the dropped push at the ports. The small depth also makes the pointer wrap happen several times inside one run.

// File: rtl/i2c_txs_pkg.sv
package i2c_txs_pkg;
  localparam int CTRL_EN_BIT    = 6;
  localparam int CTRL_FLUSH_BIT = 7;
  localparam int ST_NAK_BIT     = 0;
  localparam int ST_DRAIN_BIT   = 1;
  localparam int ST_EMPTY_BIT   = 4;
  localparam int ST_OVF_BIT     = 5;
  localparam int ST_W           = 8;

  localparam int FLG_NAK   = 0;
  localparam int FLG_DRAIN = 1;
  localparam int FLG_OVF   = 2;
  localparam int NUM_FLAGS = 3;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SHIFT,
    SQ_ACK,
    SQ_HALT
  } seq_state_e;
endpackage

// File: rtl/txs_fifo.sv
module txs_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign data_o  = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT); // R9
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> full_o); // R9
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o); // R8
endmodule

// File: rtl/txs_seq.sv
module txs_seq
  import i2c_txs_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             enable_i,
  input  logic             avail_i,
  input  logic [WIDTH-1:0] byte_i,
  output logic             pop_o,
  output logic             tx_bit_o,
  output logic             tx_bit_req_o,
  input  logic             tx_bit_done_i,
  output logic             ack_req_o,
  input  logic             ack_done_i,
  input  logic             ack_nak_i,
  output logic             acked_o,
  output logic             nak_o
);
  localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(WIDTH - 1);

  seq_state_e       state_q, state_d;
  logic [WIDTH-1:0] sh_q;
  logic [BW-1:0]    bit_q;

  assign pop_o        = (state_q == SQ_IDLE) && enable_i && avail_i && !flush_i;
  assign tx_bit_req_o = (state_q == SQ_SHIFT);
  assign tx_bit_o     = sh_q[WIDTH-1];
  assign ack_req_o    = (state_q == SQ_ACK);
  assign acked_o      = (state_q == SQ_ACK) && ack_done_i && !ack_nak_i && !flush_i;
  assign nak_o        = (state_q == SQ_ACK) && ack_done_i && ack_nak_i && !flush_i;

  always_comb begin
    state_d = state_q;
    if (flush_i) begin
      state_d = SQ_IDLE;
    end else begin
      case (state_q)
        SQ_IDLE:  if (pop_o) state_d = SQ_SHIFT;
        SQ_SHIFT: if (tx_bit_done_i && bit_q == LAST_BIT) state_d = SQ_ACK;
        SQ_ACK:   if (ack_done_i) state_d = ack_nak_i ? SQ_HALT : SQ_IDLE;
        default:  state_d = SQ_HALT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      sh_q    <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      if (flush_i) begin
        sh_q  <= '0;
        bit_q <= '0;
      end else if (pop_o) begin
        sh_q  <= byte_i;
        bit_q <= '0;
      end else if (state_q == SQ_SHIFT && tx_bit_done_i) begin
        sh_q  <= sh_q << 1;
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  AST_ONE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_bit_req_o && ack_req_o)); // R3
  AST_HALT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_HALT && !flush_i) |=> (!tx_bit_req_o && !ack_req_o)); // R7
  AST_NAK_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nak_o |=> (state_q == SQ_HALT)); // R7
  AST_FLUSH_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!tx_bit_req_o && !ack_req_o)); // R8
endmodule

// File: rtl/txs_flags.sv
module txs_flags #(
  parameter int NUM = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] set_i,
  input  logic [NUM-1:0] clr_i,
  output logic [NUM-1:0] flag_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q <= 1'b0;
      else if (set_i[g])  q <= 1'b1;
      else if (clr_i[g])  q <= 1'b0;
    end
    assign flag_o[g] = q;

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_o[g]); // R10
  end
endmodule

// File: rtl/i2c_tx_stream.sv
module i2c_tx_stream
  import i2c_txs_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [7:0]       ctrl_wdata_i,
  input  logic             data_we_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [7:0]       stat_clr_i,
  output logic [7:0]       status_o,
  output logic             tx_bit_o,
  output logic             tx_bit_req_o,
  input  logic             tx_bit_done_i,
  output logic             ack_req_o,
  input  logic             ack_done_i,
  input  logic             ack_nak_i
);
  logic             en_q, flush;
  logic             f_empty, f_full, f_pop;
  logic [WIDTH-1:0] f_head;
  logic             acked, nak;
  logic [NUM_FLAGS-1:0] fl_set, fl_clr, fl_q;
  logic             unused_bits;

  assign flush = ctrl_we_i && ctrl_wdata_i[CTRL_FLUSH_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= 1'b0;
    else if (ctrl_we_i) en_q <= ctrl_wdata_i[CTRL_EN_BIT];
  end

  txs_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (data_we_i && en_q),
    .data_i  (data_i),
    .pop_i   (f_pop),
    .data_o  (f_head),
    .empty_o (f_empty),
    .full_o  (f_full)
  );

  txs_seq #(.WIDTH(WIDTH)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush),
    .enable_i      (en_q),
    .avail_i       (!f_empty),
    .byte_i        (f_head),
    .pop_o         (f_pop),
    .tx_bit_o      (tx_bit_o),
    .tx_bit_req_o  (tx_bit_req_o),
    .tx_bit_done_i (tx_bit_done_i),
    .ack_req_o     (ack_req_o),
    .ack_done_i    (ack_done_i),
    .ack_nak_i     (ack_nak_i),
    .acked_o       (acked),
    .nak_o         (nak)
  );

  always_comb begin
    fl_set            = '0;
    fl_set[FLG_NAK]   = nak;
    fl_set[FLG_DRAIN] = acked && f_empty;
    fl_set[FLG_OVF]   = data_we_i && en_q && f_full && !flush;
    fl_clr            = '0;
    fl_clr[FLG_NAK]   = stat_clr_i[ST_NAK_BIT];
    fl_clr[FLG_DRAIN] = stat_clr_i[ST_DRAIN_BIT];
    fl_clr[FLG_OVF]   = stat_clr_i[ST_OVF_BIT];
  end

  txs_flags #(.NUM(NUM_FLAGS)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (fl_set),
    .clr_i  (fl_clr),
    .flag_o (fl_q)
  );

  always_comb begin
    status_o               = '0;
    status_o[ST_NAK_BIT]   = fl_q[FLG_NAK];
    status_o[ST_DRAIN_BIT] = fl_q[FLG_DRAIN];
    status_o[ST_EMPTY_BIT] = f_empty;
    status_o[ST_OVF_BIT]   = fl_q[FLG_OVF];
  end

  assign unused_bits = ^{ctrl_wdata_i[5:0], stat_clr_i[7:6], stat_clr_i[4:2]};

  AST_DISABLED_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && f_empty && !flush) |=> f_empty); // R2
  AST_DRAIN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[ST_DRAIN_BIT]) |-> $past(f_empty)); // R5
endmodule

// File: tb/tb_i2c_tx_stream.sv
`timescale 1ns/1ps
module tb_i2c_tx_stream;
  localparam int DEPTH = 4;
  localparam int WIDTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 0, data_we = 0, bit_done = 0, ack_done = 0, ack_nak = 0;
  logic [7:0] ctrl_wdata = 0, stat_clr = 0, status;
  logic [WIDTH-1:0] data = 0;
  logic tx_bit, bit_req, ack_req;
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  i2c_tx_stream #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .data_we_i(data_we), .data_i(data), .stat_clr_i(stat_clr), .status_o(status),
    .tx_bit_o(tx_bit), .tx_bit_req_o(bit_req), .tx_bit_done_i(bit_done),
    .ack_req_o(ack_req), .ack_done_i(ack_done), .ack_nak_i(ack_nak)
  );

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      report();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic push(input logic [7:0] v);
    @(negedge clk); data_we = 1; data = v;
    @(negedge clk); data_we = 0;
  endtask

  task automatic clr(input logic [7:0] v);
    @(negedge clk); stat_clr = v;
    @(negedge clk); stat_clr = 0;
  endtask

  task automatic wait_req(output bit ok);
    ok = 0;
    for (int i = 0; i < 50; i++) begin
      if (bit_req) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic send_bits(input int n, output logic [7:0] got);
    got = 0;
    for (int i = 0; i < n; i++) begin
      if (ack_req) chk("R3 ack during bits", 1, 0);
      got = {got[6:0], tx_bit};
      bit_done = 1; @(negedge clk); bit_done = 0;
      @(negedge clk);
    end
  endtask

  task automatic serve(input logic [7:0] exp, input logic nak, input string req);
    bit ok;
    logic [7:0] got;
    wait_req(ok);
    chk({req, " byte offered"}, int'(ok), 1);
    send_bits(8, got);
    chk({req, " byte value MSB first"}, got, exp);
    chk({req, " ack slot after 8 bits"}, int'(ack_req), 1);
    ack_nak = nak; ack_done = 1; @(negedge clk); ack_done = 0; ack_nak = 0;
  endtask

  task automatic t_reset();
    chk("R1 status after reset", status, 8'h10);
    chk("R1 requests low", int'({bit_req, ack_req}), 0);
  endtask

  task automatic t_disabled();
    push(8'h77);
    repeat (5) @(negedge clk);
    chk("R2 empty after push while disabled", status, 8'h10);
    chk("R2 no request while disabled", int'(bit_req), 0);
  endtask

  task automatic t_stream();
    ctrl(8'h40);
    push(8'hA5); push(8'h3C); push(8'hF0);
    serve(8'hA5, 0, "R4 first");
    chk("R6 empty clear while bytes stored", int'(status[4]), 0);
    chk("R5 no drain while bytes remain", int'(status[1]), 0);
    serve(8'h3C, 0, "R4 second");
    wait (bit_req); @(negedge clk);
    chk("R6 empty set while last byte in flight", int'(status[4]), 1);
    serve(8'hF0, 0, "R3 R4 third");
    chk("R5 drain after last ack", status, 8'h12);
    clr(8'h02);
    chk("R10 drain cleared by write 1", status, 8'h10);
  endtask

  task automatic t_nak();
    push(8'h11); push(8'h22);
    serve(8'h11, 1, "R7 nak byte");
    chk("R7 nak flag, byte still stored", status, 8'h01);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (bit_req || ack_req) chk("R7 quiet while halted", 1, 0);
    end
    chk("R7 halt held", int'(bit_req), 0);
    ctrl(8'hC0);
    chk("R8 flush empties, nak flag sticky", status, 8'h11);
    repeat (3) @(negedge clk);
    chk("R8 discarded byte not sent", int'(bit_req), 0);
    clr(8'h01);
    push(8'h5A);
    serve(8'h5A, 0, "R8 stream resumes");
    clr(8'h02);
  endtask

  task automatic t_overflow();
    push(8'h01);
    serve(8'h01, 1, "R9 halt setup");
    for (int i = 0; i < DEPTH; i++) push(8'h90 + 8'(i));
    chk("R9 no ovf at exactly full", int'(status[5]), 0);
    push(8'hEE);
    chk("R9 ovf flag on dropped push", int'(status[5]), 1);
    @(negedge clk); stat_clr = 8'h20; data_we = 1; data = 8'hEF;
    @(negedge clk); stat_clr = 0; data_we = 0;
    chk("R10 set wins over clear", int'(status[5]), 1);
    ctrl(8'hC0);
    clr(8'h21);
    chk("R9 flags cleared after flush", status, 8'h10);
    push(8'h90);
    serve(8'h90, 0, "R9 new byte after full");
    clr(8'h02);
  endtask

  task automatic t_abort();
    bit ok;
    logic [7:0] got;
    push(8'hC3);
    wait_req(ok);
    send_bits(3, got);
    chk("R4 partial bits", got, 8'h06);
    ctrl(8'hC0);
    chk("R8 flush aborts byte", int'({bit_req, ack_req}), 0);
    chk("R8 no drain on abort", status, 8'h10);
    push(8'h81);
    serve(8'h81, 0, "R8 clean byte after abort");
    chk("R5 drain after resumed byte", status, 8'h12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_stream();
    t_nak();
    t_overflow();
    t_abort();
    report();
  end
endmodule